// File: doc/BRIEF.md
# Register Write-Protection Unlock Controller

This block sits on a simple synchronous register bus and decides, for every write, which bits of the addressed control register may change. A group of sensitive control registers is normally locked, and writes to their protected bits are silently dropped. To open them, software writes a three-value key to a dedicated key register: first 0x59, then 0x16, then 0x88. Only the low byte of each key write is compared. Once the key is accepted, all protected bits are writable until software writes the key register again, which locks the group.

Protection is defined per register and, where needed, per bit. A small demonstration bank of five registers shows the cases the controller has to handle:
- two registers that are fully protected;
- one register that is protected except bit 6;
- one register where only bits [1:0] are protected;
- one register with no protection.

For each write the block drives a bit-enable vector. Its bit pattern shows which bits of the write will take effect.

Top module: `wp_unlock_ctrl`

## Requirements
- R1: After reset the group is locked, the key register (byte offset 0x40) reads 0, all bank registers read 0 and `bus_ready` is low.
- R2: Three writes to offset 0x40 whose low bytes are 0x59, 0x16 and 0x88, in that order, unlock the group. Bit 0 of the key register then reads 1, and `unlocked` goes high in the cycle after the third write.
- R3: While locked, a write leaves the protected bits of the target register unchanged. Bank offset 0x00 and offset 0x04 are fully protected.
- R4: While unlocked, every bit of every bank register is written as given.
- R5: If a key write carries a low byte other than the one expected next, the sequence starts over. If that byte is 0x59, it counts as the first step of a new sequence.
- R6: Any write to the key register while unlocked locks the group again. Such a write never counts as a first step.
- R7: Writes and reads to other addresses between key writes leave the sequence progress untouched.
- R8: At offset 0x08 only bit 6 is writable while locked. At offset 0x0C only bits [1:0] are protected. Offset 0x10 is never protected.
- R9: `wr_bit_en` is zero whenever no write is presented. During a write to a bank register, it shows exactly the bits that the write will update.
- R10: `bus_ready` is high in the cycle after every selected access. Read data is valid at the same time. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | Access completed |
| unlocked | output | 1 | Protected group is open |
| wr_bit_en | output | 32 | Bits updated by the current write |

## Verification
On every cycle, the assertions check the following:
- `unlocked` rises only right after a 0x88 key write, and changes only on a key write.
- A key write while open always closes the group.
- The fully protected register cannot move while locked.
- The free bit 6 always follows the data written to it.
- `wr_bit_en` is quiet when no write is presented.
- `bus_ready` tracks the select signal.

Only the directed scenarios can show the rest: that the full ordered key actually opens the group, that a broken sequence restarts correctly (including the 0x59 restart case), that unrelated traffic between key writes is tolerated, and the exact per-bit read-back values of the partially protected registers.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned BANK_REGS = 5;

  localparam logic [7:0] KEY_FIRST  = 8'h59;
  localparam logic [7:0] KEY_SECOND = 8'h16;
  localparam logic [7:0] KEY_THIRD  = 8'h88;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    KS_IDLE = 2'd0,
    KS_ONE  = 2'd1,
    KS_TWO  = 2'd2,
    KS_OPEN = 2'd3
  } key_state_e;

  // Bits of each bank register that need the group to be open.
  function automatic word_t lock_mask(int unsigned idx);
    word_t m;
    case (idx)
      0, 1:    m = '1;
      2:       m = ~(word_t'(1) << 6);
      3:       m = word_t'(3);
      default: m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/wp_key_seq.sv
module wp_key_seq
  import wp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_byte,
  output logic       open_q
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (key_wr) begin
      unique case (state_q)
        KS_IDLE: state_d = (key_byte == KEY_FIRST) ? KS_ONE : KS_IDLE;
        KS_ONE: begin
          if (key_byte == KEY_SECOND)     state_d = KS_TWO;
          else if (key_byte == KEY_FIRST) state_d = KS_ONE;
          else                            state_d = KS_IDLE;
        end
        KS_TWO: begin
          if (key_byte == KEY_THIRD)      state_d = KS_OPEN;
          else if (key_byte == KEY_FIRST) state_d = KS_ONE;
          else                            state_d = KS_IDLE;
        end
        KS_OPEN: state_d = KS_IDLE;
        default: state_d = KS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state_q <= KS_IDLE;
    else if (key_wr) state_q <= state_d;
  end

  assign open_q = (state_q == KS_OPEN);
endmodule

// File: rtl/wp_prot_filter.sv
module wp_prot_filter
  import wp_pkg::*;
#(
  parameter int unsigned SEL_W = 3
) (
  input  logic             wr_req,
  input  logic             bank_hit,
  input  logic [SEL_W-1:0] bank_sel,
  input  logic             open_q,
  output word_t            bit_en
);
  word_t guard;

  always_comb begin
    guard  = lock_mask(32'(bank_sel));
    bit_en = '0;
    if (wr_req && bank_hit) begin
      bit_en = open_q ? '1 : ~guard;
    end
  end
endmodule

// File: rtl/wp_demo_bank.sv
module wp_demo_bank
  import wp_pkg::*;
#(
  parameter int unsigned NREGS = BANK_REGS,
  localparam int unsigned SEL_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_req,
  input  logic [SEL_W-1:0]             sel,
  input  word_t                        wdata,
  input  word_t                        bit_en,
  output logic [NREGS-1:0][WORD_W-1:0] q
);
  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    logic  hit;
    word_t d;

    assign hit = wr_req && (sel == SEL_W'(i));

    always_comb begin
      d = (q[i] & ~bit_en) | (wdata & bit_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q[i] <= '0;
      else if (hit) q[i] <= d;
    end
  end
endmodule

// File: rtl/wp_unlock_ctrl.sv
module wp_unlock_ctrl
  import wp_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned KEY_OFFSET = 'h40,
  localparam int unsigned IDX_W = ADDR_W - 2,
  localparam int unsigned SEL_W = (BANK_REGS > 1) ? $clog2(BANK_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              bus_ready,
  output logic              unlocked,
  output logic [WORD_W-1:0] wr_bit_en
);
  logic [IDX_W-1:0] word_idx;
  logic [SEL_W-1:0] bank_sel;
  logic             aligned, key_hit, bank_hit, wr_req, rd_req, key_wr;
  logic [BANK_REGS-1:0][WORD_W-1:0] bank_q;
  word_t            rd_d;

  assign word_idx = bus_addr[ADDR_W-1:2];
  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign key_hit  = aligned && (word_idx == IDX_W'(KEY_OFFSET >> 2));
  assign bank_hit = aligned && (32'(word_idx) < BANK_REGS);
  assign bank_sel = word_idx[SEL_W-1:0];
  assign wr_req   = bus_sel && bus_wr;
  assign rd_req   = bus_sel && !bus_wr;
  assign key_wr   = wr_req && key_hit;

  wp_key_seq u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (key_wr),
    .key_byte (bus_wdata[7:0]),
    .open_q   (unlocked)
  );

  wp_prot_filter #(.SEL_W(SEL_W)) u_filter (
    .wr_req   (wr_req),
    .bank_hit (bank_hit),
    .bank_sel (bank_sel),
    .open_q   (unlocked),
    .bit_en   (wr_bit_en)
  );

  wp_demo_bank #(.NREGS(BANK_REGS)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_req (wr_req && bank_hit),
    .sel    (bank_sel),
    .wdata  (bus_wdata),
    .bit_en (wr_bit_en),
    .q      (bank_q)
  );

  always_comb begin
    rd_d = '0;
    if (key_hit)       rd_d = word_t'(unlocked);
    else if (bank_hit) rd_d = bank_q[bank_sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ready <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ready <= bus_sel;
      if (rd_req) bus_rdata <= rd_d;
      else        bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/wp_unlock_chk.sv
module wp_unlock_chk
  import wp_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned KEY_OFFSET = 'h40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        key_byte,
  input logic              free_bit,
  input logic              bus_ready,
  input logic              unlocked,
  input logic [WORD_W-1:0] wr_bit_en,
  input logic [WORD_W-1:0] rst_reg_q,
  input logic              pwr_bit6_q
);
  logic key_write, pwr_write;
  assign key_write = bus_sel && bus_wr && (bus_addr == ADDR_W'(KEY_OFFSET));
  assign pwr_write = bus_sel && bus_wr && (bus_addr == ADDR_W'(8'h08));

  assert_unlock_after_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(key_write && key_byte == KEY_THIRD));

  assert_locked_reg_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(rst_reg_q));

  assert_key_write_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && key_write) |=> !unlocked);

  assert_lock_moves_on_key_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !key_write |=> $stable(unlocked));

  assert_free_bit_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_write |=> (pwr_bit6_q == $past(free_bit)));

  assert_no_enable_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr) |-> (wr_bit_en == '0));

  assert_ready_follows_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel |=> bus_ready);

  assert_ready_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> !bus_ready);
endmodule

bind wp_unlock_ctrl wp_unlock_chk #(.ADDR_W(ADDR_W), .KEY_OFFSET(KEY_OFFSET)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .key_byte   (bus_wdata[7:0]),
  .free_bit   (bus_wdata[6]),
  .bus_ready  (bus_ready),
  .unlocked   (unlocked),
  .wr_bit_en  (wr_bit_en),
  .rst_reg_q  (bank_q[0]),
  .pwr_bit6_q (bank_q[2][6])
);

// File: tb/wp_unlock_ctrl_test.sv
module wp_unlock_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, wr_bit_en;
  logic        bus_ready, unlocked;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  localparam logic [7:0] A_KEY = 8'h40;

  always #5 clk = ~clk;

  wp_unlock_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .unlocked(unlocked), .wr_bit_en(wr_bit_en)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, output logic [31:0] en);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    #1 en = wr_bit_en;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic wrq(logic [7:0] a, logic [31:0] d);
    logic [31:0] en;
    wr(a, d, en);
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    chk("R10 ready after read", 32'(bus_ready), 32'd1);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic open_key();
    wrq(A_KEY, 32'h59); wrq(A_KEY, 32'h16); wrq(A_KEY, 32'h88);
  endtask

  task automatic t_reset();
    chk("R1 locked at reset", 32'(unlocked), 32'd0);
    chk("R1 ready low at reset", 32'(bus_ready), 32'd0);
    chk("R9 no enable when idle", wr_bit_en, 32'd0);
    rd_chk("R1 key reads 0", A_KEY, 32'd0);
    rd_chk("R1 bank reg reads 0", 8'h04, 32'd0);
  endtask

  task automatic t_locked();
    logic [31:0] en;
    wr(8'h00, 32'hFFFF_FFFF, en);
    chk("R9 enable zero for locked reg", en, 32'd0);
    rd_chk("R3 locked write ignored", 8'h00, 32'd0);
    wrq(8'h04, 32'h1234_5678);
    rd_chk("R3 second protected reg ignored", 8'h04, 32'd0);
    wr(8'h08, 32'hFFFF_FFFF, en);
    chk("R9 enable only bit6", en, 32'h0000_0040);
    rd_chk("R8 bit6 writable while locked", 8'h08, 32'h0000_0040);
    wr(8'h0C, 32'hFFFF_FFFF, en);
    chk("R9 enable outside [1:0]", en, 32'hFFFF_FFFC);
    rd_chk("R8 only [1:0] protected", 8'h0C, 32'hFFFF_FFFC);
    wrq(8'h10, 32'hDEAD_BEEF);
    rd_chk("R8 open register", 8'h10, 32'hDEAD_BEEF);
    rd_chk("R10 unmapped reads 0", 8'h20, 32'd0);
  endtask

  task automatic t_unlock();
    logic [31:0] en;
    open_key();
    chk("R2 unlocked after key", 32'(unlocked), 32'd1);
    rd_chk("R2 key bit0 reads 1", A_KEY, 32'd1);
    wr(8'h00, 32'hA5A5_A5A5, en);
    chk("R9 full enable when open", en, 32'hFFFF_FFFF);
    rd_chk("R4 protected write lands", 8'h00, 32'hA5A5_A5A5);
    wrq(8'h0C, 32'h0000_0003);
    rd_chk("R4 guarded bits written", 8'h0C, 32'h0000_0003);
  endtask

  task automatic t_relock();
    wrq(A_KEY, 32'h59);
    chk("R6 key write relocks", 32'(unlocked), 32'd0);
    rd_chk("R6 key reads 0", A_KEY, 32'd0);
    wrq(8'h00, 32'd0);
    rd_chk("R6 relocked reg held", 8'h00, 32'hA5A5_A5A5);
    wrq(A_KEY, 32'h16); wrq(A_KEY, 32'h88);
    chk("R6 relock write not step one", 32'(unlocked), 32'd0);
  endtask

  task automatic t_break();
    wrq(A_KEY, 32'h59); wrq(A_KEY, 32'h16); wrq(A_KEY, 32'h00); wrq(A_KEY, 32'h88);
    chk("R5 broken sequence stays locked", 32'(unlocked), 32'd0);
    wrq(A_KEY, 32'h59); wrq(A_KEY, 32'h59); wrq(A_KEY, 32'h16); wrq(A_KEY, 32'h88);
    chk("R5 repeated 0x59 restarts", 32'(unlocked), 32'd1);
    wrq(A_KEY, 32'h0);
    wrq(A_KEY, 32'h59); wrq(A_KEY, 32'h16); wrq(A_KEY, 32'h59);
    wrq(A_KEY, 32'h16); wrq(A_KEY, 32'h88);
    chk("R5 0x59 at step three restarts", 32'(unlocked), 32'd1);
    wrq(A_KEY, 32'h0);
    chk("R6 locked again", 32'(unlocked), 32'd0);
  endtask

  task automatic t_interleave();
    logic [31:0] d;
    wrq(A_KEY, 32'h59);
    wrq(8'h10, 32'h0000_1111);
    rd(8'h04, d);
    wrq(A_KEY, 32'h16);
    wrq(8'h00, 32'h0);
    wrq(A_KEY, 32'h88);
    chk("R7 sequence survives traffic", 32'(unlocked), 32'd1);
    rd_chk("R3 write between keys ignored", 8'h00, 32'hA5A5_A5A5);
    wrq(A_KEY, 32'h0);
    wrq(8'h08, 32'h0);
    rd_chk("R8 bit6 cleared while locked", 8'h08, 32'd0);
    @(negedge clk);
    chk("R10 ready low when idle", 32'(bus_ready), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked();
    t_unlock();
    t_relock();
    t_break();
    t_interleave();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule